// File: doc/BRIEF.md
# Serial ADC Output Sequencer

This block is the digital back end of a successive-approximation converter with a parameterised resolution (12 bits by default). A single control input, `conv_ctl`, runs it. A falling transition of that input while the block is idle starts a conversion. The block captures the parallel `result_word` at that instant. The word stands in for the comparator decisions. The block then presents the result serially, most significant bit first, one bit per clock. Outputs change on the falling clock edge, so a receiver can latch each bit on the next rising edge.

The same control input has two more uses during a conversion. It can cut the conversion short, which ends it early and floats the data pin at once. It can also request a second readout that replays the word least significant bit first. Status outputs report the power state, the sample/hold phase and how many bits were actually delivered. A host can use that count to tell a full result from a truncated one.

The serial stream has no back-pressure: a bit is valid for exactly one clock while `sdata_oe` is high, and the receiver must take it on the following rising edge. The tri-state pin `sdata_pin` follows `sdata` when enabled and floats otherwise.

Top module: `adc_serial_seq`

## Requirements
- R1: After reset `sdata_oe` is 0, `low_pwr` is 1, `hold` is 0 and `bits_valid` is 0.
- R2: A conversion starts on the rising edge that samples `conv_ctl` low after it was sampled high in the previous edge while idle; during that first clock `hold` is 1, `low_pwr` is 0 and no bit is driven (`sdata_oe` 0).
- R3: In clocks 2 to 13 of a conversion (counting the start clock as 1), `sdata_oe` is 1 and `sdata` carries bit index 11 down to bit index 0 of the captured word, one per clock.
- R4: When no early stop occurs, `low_pwr` goes to 1 in clock 13, the pin floats from clock 14 on, and `bits_valid` reads 12.
- R5: If `conv_ctl` was sampled high during the conversion and is then sampled low at the edge ending clock c, with 2 <= c <= 12, the block returns to idle at that edge with `low_pwr` 1 and `bits_valid` = c-2, and no further bits follow.
- R6: In that early-stop case the output enable falls as soon as `conv_ctl` falls, without waiting for a clock edge.
- R7: If `conv_ctl` was sampled high during the conversion and falls during clock 13, the pin stays driven with bit 0, then clocks 14 to 24 carry bit indices 1 up to 11, with `low_pwr` 1 throughout, and the pin floats afterwards.
- R8: `hold` is 1 exactly during clocks 1 to 13 of a conversion and 0 in idle and during the reversed replay.
- R9: Holding `conv_ctl` low in idle does not start another conversion.
- R10: Changes of `result_word` after the start edge have no effect on the serial bits of that conversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock; state on rising edge, outputs on falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_ctl | input | 1 | Start, early-stop and replay control |
| result_word | input | RES_W | Parallel result, captured at the start edge |
| sdata | output | 1 | Serial data value |
| sdata_oe | output | 1 | Drive enable for the data pin |
| sdata_pin | output | 1 | Tri-state data pin |
| low_pwr | output | 1 | 1 when in low-power state |
| hold | output | 1 | 1 in hold phase, 0 in sample phase |
| bits_valid | output | $clog2(RES_W+1) | Bits delivered by the last finished conversion |

## Verification
The early stop and the replay request share one boundary. A fall of `conv_ctl` in clock 12 truncates the word. The same fall one clock later, in clock 13, coincides with the last MSB-first bit and the drop to low power, and turns into a replay instead. The bench provokes both, plus stops in clock 2 and clock 7. For each case its scoreboard holds exactly the bits the requirements allow. The bench judges the pin enable just before and just after the control edge, the final `bits_valid`, and that the queue drains with no unexpected bit.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/100ps
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_CONV   = 2'd1,
    ST_REPLAY = 2'd2
  } seq_state_t;
endpackage

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/100ps
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int RES_W = 12,
  parameter int CW    = 5,
  parameter int VW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl,
  output seq_state_t    state,
  output logic [CW-1:0] cnt,
  output logic          start,
  output logic          cut_window,
  output logic          cut_q,
  output logic [VW-1:0] bits_valid
);
  localparam logic [CW-1:0] K_RES  = CW'(RES_W);
  localparam logic [CW-1:0] K_LAST = CW'(RES_W + 1);
  localparam logic [CW-1:0] K_REP  = CW'(2 * RES_W);
  localparam logic [CW-1:0] K_TWO  = CW'(2);

  logic ctl_prev;
  logic armed;
  logic end_conv;
  logic stop_req;
  logic short_stop;

  assign start      = (state == ST_IDLE) && ctl_prev && !ctl;
  assign end_conv   = (state == ST_CONV) && (cnt == K_LAST);
  assign stop_req   = (state == ST_CONV) && armed && !ctl;
  assign short_stop = stop_req && (cnt <= K_RES);
  assign cut_window = (state == ST_CONV) && armed && (cnt <= K_RES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      ctl_prev   <= 1'b0;
      armed      <= 1'b0;
      cut_q      <= 1'b0;
      bits_valid <= '0;
    end else begin
      ctl_prev <= ctl;
      cut_q    <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_CONV;
            cnt   <= CW'(1);
            armed <= 1'b0;
          end
        end
        ST_CONV: begin
          if (ctl && (cnt <= K_RES)) armed <= 1'b1;
          if (short_stop) begin
            state      <= ST_IDLE;
            cnt        <= '0;
            cut_q      <= 1'b1;
            bits_valid <= (cnt >= K_TWO) ? VW'(cnt - K_TWO) : '0;
          end else if (end_conv) begin
            bits_valid <= VW'(RES_W);
            if (stop_req) begin
              state <= ST_REPLAY;
              cnt   <= cnt + CW'(1);
            end else begin
              state <= ST_IDLE;
              cnt   <= '0;
            end
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        ST_REPLAY: begin
          if (cnt == K_REP) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        default: begin
          state <= ST_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

  // R2: a qualified control fall opens clock 1 of a conversion
  a_r2_start_enters_conv: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (state == ST_CONV && cnt == CW'(1)));

  // R4: an undisturbed clock 13 closes with a full count
  a_r4_full_count: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CONV && cnt == K_LAST && !(armed && !ctl))
      |=> (state == ST_IDLE && bits_valid == VW'(RES_W)));

  // R5: an early stop returns to idle and keeps the pin cut for one clock
  a_r5_short_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CONV && armed && !ctl && cnt <= K_RES)
      |=> (state == ST_IDLE && cut_q));

  // R7: the replay only spans clocks 14 to 24
  a_r7_replay_span: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_REPLAY) |-> (cnt > K_LAST && cnt <= K_REP));

  // R9: idle with the control input already low stays idle
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !ctl_prev) |=> (state == ST_IDLE));
endmodule

// File: rtl/adc_seq_bitsel.sv
`timescale 1ns/100ps
module adc_seq_bitsel
  import adc_seq_pkg::*;
#(
  parameter int RES_W = 12,
  parameter int CW    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [RES_W-1:0] word_in,
  input  seq_state_t       state,
  input  logic [CW-1:0]    cnt,
  output logic             bit_en,
  output logic             bit_val
);
  logic [RES_W-1:0] word_q;
  logic [RES_W-1:0] word_rev;
  logic [RES_W-1:0] sel_msb;
  logic [RES_W-1:0] sel_lsb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    word_q <= '0;
    else if (load) word_q <= word_in;
  end

  // sel_msb[g]: clock g+2 of a conversion carries word bit RES_W-1-g
  // sel_lsb[g]: clock RES_W+1+g of the replay carries word bit g (g >= 1)
  for (genvar g = 0; g < RES_W; g++) begin : g_sel
    assign word_rev[g] = word_q[RES_W-1-g];
    assign sel_msb[g]  = (state == ST_CONV) && (cnt == CW'(g + 2));
    if (g == 0) begin : g_no_lsb0
      assign sel_lsb[g] = 1'b0;
    end else begin : g_lsb
      assign sel_lsb[g] = (state == ST_REPLAY) && (cnt == CW'(RES_W + 1 + g));
    end
  end

  assign bit_en  = (|sel_msb) | (|sel_lsb);
  assign bit_val = |((sel_msb & word_rev) | (sel_lsb & word_q));

  // R3: at most one bit position is selected in any clock
  a_r3_one_bit_selected: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_msb, sel_lsb}));
endmodule

// File: rtl/adc_seq_pad.sv
`timescale 1ns/100ps
module adc_seq_pad (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic bit_val,
  input  logic kill,
  output logic oe,
  output logic dout
);
  logic oe_q;
  logic d_q;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q <= 1'b0;
      d_q  <= 1'b0;
    end else begin
      oe_q <= bit_en;
      d_q  <= bit_en & bit_val;
    end
  end

  assign oe   = oe_q & ~kill;
  assign dout = d_q;
endmodule

// File: rtl/adc_serial_seq.sv
`timescale 1ns/100ps
module adc_serial_seq
  import adc_seq_pkg::*;
#(
  parameter  int RES_W = 12,
  localparam int CW    = $clog2(2 * RES_W + 1),
  localparam int VW    = $clog2(RES_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_ctl,
  input  logic [RES_W-1:0] result_word,
  output logic             sdata,
  output logic             sdata_oe,
  output wire              sdata_pin,
  output logic             low_pwr,
  output logic             hold,
  output logic [VW-1:0]    bits_valid
);
  localparam logic [CW-1:0] K_RES = CW'(RES_W);

  seq_state_t    state;
  logic [CW-1:0] cnt;
  logic          start;
  logic          cut_window;
  logic          cut_q;
  logic          bit_en;
  logic          bit_val;
  logic          kill;

  adc_seq_ctrl #(.RES_W(RES_W), .CW(CW), .VW(VW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl        (conv_ctl),
    .state      (state),
    .cnt        (cnt),
    .start      (start),
    .cut_window (cut_window),
    .cut_q      (cut_q),
    .bits_valid (bits_valid)
  );

  adc_seq_bitsel #(.RES_W(RES_W), .CW(CW)) u_bitsel (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (start),
    .word_in (result_word),
    .state   (state),
    .cnt     (cnt),
    .bit_en  (bit_en),
    .bit_val (bit_val)
  );

  assign kill = (cut_window & ~conv_ctl) | cut_q;

  adc_seq_pad u_pad (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_en  (bit_en),
    .bit_val (bit_val),
    .kill    (kill),
    .oe      (sdata_oe),
    .dout    (sdata)
  );

  assign sdata_pin = sdata_oe ? sdata : 1'bz;
  assign hold      = (state == ST_CONV);
  assign low_pwr   = !((state == ST_CONV) && (cnt <= K_RES));

  // R6: a stop request inside the cut window floats the pin at once
  a_r6_immediate_float: assert property (@(posedge clk) disable iff (!rst_n)
    (cut_window && !conv_ctl) |-> !sdata_oe);

  // R8: full power is only ever seen in the hold phase
  a_r8_power_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !low_pwr |-> hold);
endmodule

// File: tb/sim_adc_serial_seq.sv
`timescale 1ns/100ps
module sim_adc_serial_seq;
  localparam int RES_W = 12;
  localparam int VW    = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          conv_ctl = 1'b1;
  logic [11:0]   result_word = '0;
  wire           sdata, sdata_oe, sdata_pin, low_pwr, hold;
  wire [VW-1:0]  bits_valid;

  always #4 clk = ~clk;

  adc_serial_seq #(.RES_W(RES_W)) u0 (
    .clk(clk), .rst_n(rst_n), .conv_ctl(conv_ctl), .result_word(result_word),
    .sdata(sdata), .sdata_oe(sdata_oe), .sdata_pin(sdata_pin),
    .low_pwr(low_pwr), .hold(hold), .bits_valid(bits_valid)
  );

  int    checks = 0;
  int    fails  = 0;
  bit    finished = 0;
  bit    exp_q[$];
  string cur_req = "R3";

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // monitor: receiver latches at the rising edge; sample 2 ns later
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rst_n && sdata_oe === 1'b1) begin
        if (exp_q.size() == 0) check(cur_req, 1, 0, "unexpected serial bit");
        else check(cur_req, int'(sdata), int'(exp_q.pop_front()), "serial bit");
      end
    end
  end

  task automatic push_msb(input logic [11:0] w, input int n);
    for (int i = 0; i < n; i++) exp_q.push_back(w[11-i]);
  endtask

  task automatic push_replay(input logic [11:0] w);
    for (int j = 1; j < 12; j++) exp_q.push_back(w[j]);
  endtask

  task automatic settle_high();
    conv_ctl = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // full MSB-first conversion; optionally disturb result_word (R10)
  task automatic run_normal(input logic [11:0] w, input bit disturb);
    cur_req = disturb ? "R10" : "R3";
    result_word = w;
    push_msb(w, 12);
    @(negedge clk); #1 conv_ctl = 1'b0;
    @(posedge clk); #2;
    check("R2", int'(hold), 1, "hold in clock 1");
    check("R2", int'(low_pwr), 0, "low_pwr in clock 1");
    check("R2", int'(sdata_oe), 0, "no bit in clock 1");
    if (disturb) result_word = ~w;
    repeat (12) @(posedge clk);
    #2;
    check("R4", int'(low_pwr), 1, "low_pwr in clock 13");
    check("R8", int'(hold), 1, "hold in clock 13");
    @(posedge clk); #2;
    check("R8", int'(hold), 0, "hold after conversion");
    @(negedge clk); #1;
    check("R4", int'(sdata_oe), 0, "pin floats after clock 13");
    check("R4", int'(bits_valid), 12, "bits_valid full");
    check(cur_req, exp_q.size(), 0, "bits left undelivered");
    result_word = w;
  endtask

  // early stop: control falls during clock c
  task automatic run_short(input logic [11:0] w, input int c);
    cur_req = "R5";
    result_word = w;
    push_msb(w, c - 2);
    @(negedge clk); #1 conv_ctl = 1'b0;
    @(negedge clk); #1 conv_ctl = 1'b1;
    repeat (c - 1) @(negedge clk);
    #0.5;
    check("R6", int'(sdata_oe), 1, "pin driven before stop");
    #0.5 conv_ctl = 1'b0;
    #0.5;
    check("R6", int'(sdata_oe), 0, "pin floats at stop");
    @(posedge clk); #2;
    check("R5", int'(hold), 0, "idle after stop");
    check("R5", int'(low_pwr), 1, "low_pwr after stop");
    check("R5", int'(bits_valid), c - 2, "bits_valid after stop");
    check("R5", int'(sdata_oe), 0, "pin floats after stop");
    @(negedge clk); #1;
    check("R5", exp_q.size(), 0, "bits left undelivered");
    settle_high();
  endtask

  // replay: control falls during clock 13
  task automatic run_replay(input logic [11:0] w);
    cur_req = "R7";
    result_word = w;
    push_msb(w, 12);
    push_replay(w);
    @(negedge clk); #1 conv_ctl = 1'b0;
    @(negedge clk); #1 conv_ctl = 1'b1;
    repeat (12) @(negedge clk);
    #1 conv_ctl = 1'b0;
    #0.5;
    check("R7", int'(sdata_oe), 1, "bit 0 stays driven in clock 13");
    @(posedge clk); #2;
    check("R8", int'(hold), 0, "sample phase during replay");
    check("R7", int'(low_pwr), 1, "low_pwr during replay");
    repeat (5) @(posedge clk);
    #2;
    check("R7", int'(low_pwr), 1, "low_pwr mid replay");
    repeat (6) @(posedge clk);
    @(negedge clk); #1;
    check("R7", int'(sdata_oe), 0, "pin floats after replay");
    check("R7", exp_q.size(), 0, "replay bits left undelivered");
    check("R7", int'(bits_valid), 12, "bits_valid after replay");
    // control still low: no new conversion (R9)
    repeat (20) @(posedge clk);
    #2;
    check("R9", int'(hold), 0, "no restart while held low");
    check("R9", int'(sdata_oe), 0, "no bits while held low");
    settle_high();
  endtask

  // control raised during conversion but never lowered: full result
  task automatic run_armed_hold(input logic [11:0] w);
    cur_req = "R4";
    result_word = w;
    push_msb(w, 12);
    @(negedge clk); #1 conv_ctl = 1'b0;
    @(negedge clk); #1 conv_ctl = 1'b1;
    repeat (14) @(negedge clk);
    #1;
    check("R4", int'(sdata_oe), 0, "pin floats, raised control");
    check("R4", int'(bits_valid), 12, "bits_valid, raised control");
    check("R4", exp_q.size(), 0, "bits left, raised control");
    settle_high();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", int'(sdata_oe), 0, "reset oe");
    check("R1", int'(low_pwr), 1, "reset low_pwr");
    check("R1", int'(hold), 0, "reset hold");
    check("R1", int'(bits_valid), 0, "reset bits_valid");
    #1 rst_n = 1'b1;
    settle_high();
    run_normal(12'hA5C, 1'b0);
    repeat (20) @(posedge clk);
    #2;
    check("R9", int'(hold), 0, "held low after normal end");
    settle_high();
    run_normal(12'h3F1, 1'b1);
    settle_high();
    run_short(12'hB37, 7);
    run_short(12'hFFF, 2);
    run_short(12'h9D2, 12);
    run_replay(12'hC4B);
    run_armed_hold(12'h0E6);
    run_normal(12'h001, 1'b0);
    settle_high();
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog run did not complete actual=1 expected=0");
      summary();
      $finish;
    end
  end
endmodule